// File: doc/BRIEF.md
# Flash Status Register and Ready Pin

This block keeps the status byte of a flash memory device and drives its open-drain ready/interrupt pin. The command sequencer and the operation engine feed it raw facts: whether an operation is running, whether an erase or a write is suspended, one-cycle error events, and one-cycle completion events for erase and write. From these it builds a live status byte. It keeps the error flags set until a clear command is accepted. It gives a frozen copy of the status to the read path.

A read strobe (output-enable and chip-enable, combined and active high here) takes a snapshot on its leading edge. The snapshot stays frozen until the strobe goes inactive and then active again. Two status-related commands are decoded on the command write bus:
- A single-cycle clear command (50H) resets the error flags.
- A two-cycle pin configuration command (B8H followed by a mode code) picks how the pin behaves. In level mode the pin is pulled low while the engine is busy. In the pulse modes it is pulled low for a fixed number of clocks after each qualifying completion.

The pin is modelled as a drive-enable output plus a constant low value.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the snapshot output reads 80H, the pin is not driven, and the pin mode is level mode.
- R2: Bit 7 of the status is 1 when the engine is idle and 0 when it is busy. Bit 6 mirrors the erase-suspend input, bit 2 mirrors the write-suspend input, and bit 0 always reads 0.
- R3: The error event inputs bit 0, 1, 2 and 3 set status bits 1, 3, 4 and 5 respectively, and each set flag stays set until a clear is accepted.
- R4: A write of 50H, while idle and not suspended, clears all four error flags.
- R5: A write of 50H while the engine is busy, or while erase or write is suspended, leaves the error flags unchanged.
- R6: An error event in the same cycle as an accepted clear leaves its own flag set, while the other flags clear.
- R7: The snapshot is captured on the first cycle the read strobe is high and appears on the status output one clock later. It holds while the strobe stays high, and a new value appears only after the strobe drops and rises again.
- R8: In level mode the pin is driven exactly while the engine is busy.
- R9: A write of B8H followed by a second write selects the pin mode: 00H level, 01H pulse on erase completion, 02H pulse on write completion, 03H pulse on both. Any other second code leaves the mode unchanged. The second write is consumed by the configuration command and is never taken as a clear.
- R10: In a pulse mode a qualifying completion drives the pin for exactly PULSE_CLKS clocks, starting the cycle after the event. A completion of the other kind does not drive the pin.
- R11: In a pulse mode the busy input does not drive the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the deep power-down state |
| cmd_valid | input | 1 | Command bus write strobe, one cycle per write |
| cmd_data | input | 8 | Command bus write data |
| eng_busy | input | 1 | Operation engine running |
| erase_susp | input | 1 | Erase suspended |
| write_susp | input | 1 | Write suspended |
| err_evt | input | 4 | One-cycle error events, bits 0..3 map to status bits 1,3,4,5 |
| done_erase | input | 1 | One-cycle pulse when an erase finishes |
| done_write | input | 1 | One-cycle pulse when a write finishes |
| rd_en | input | 1 | Status read strobe, active high |
| status_rd | output | 8 | Latched status snapshot |
| sts_oe | output | 1 | Pin drive enable (pin pulled low when 1) |
| sts_out | output | 1 | Pin value when driven, always 0 |

## Verification
A wrong error flag shows up in the next snapshot, so it is visible one clock after the next rising read strobe. Reads taken while the strobe stays high would hide it. A wrongly accepted or wrongly rejected clear is seen in the same way on the next fresh read. A wrong pin mode, or a counter that is off by one, shows at `sts_oe` within a cycle of the next busy change or completion event. The pulse length is counted cycle by cycle against PULSE_CLKS.

// File: rtl/fsu_pkg.sv
`timescale 1ns/1ps
package fsu_pkg;
   typedef enum logic [1:0] {
      PIN_LEVEL       = 2'd0,
      PIN_PULSE_ERASE = 2'd1,
      PIN_PULSE_WRITE = 2'd2,
      PIN_PULSE_BOTH  = 2'd3
   } pin_mode_t;

   localparam int unsigned SR_W     = 8;
   localparam int unsigned ERR_N    = 4;
   localparam logic [7:0]  CMD_CLR  = 8'h50;
   localparam logic [7:0]  CMD_PCFG = 8'hB8;
   localparam int unsigned POS_RDY  = 7;
   localparam int unsigned POS_ESUS = 6;
   localparam int unsigned POS_WSUS = 2;
   localparam int unsigned ERR_POS [ERR_N] = '{1, 3, 4, 5};
   localparam logic [SR_W-1:0] SR_RESET = 8'h80;
endpackage

// File: rtl/fsu_cmd_decode.sv
`timescale 1ns/1ps
module fsu_cmd_decode
   import fsu_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_valid,
   input  logic [7:0] cmd_data,
   input  logic      op_quiet,
   output logic      clr_req,
   output logic      mode_wr,
   output logic      cfg_pend,
   output pin_mode_t pin_mode
);
   logic pend_q;
   pin_mode_t mode_q;

   assign mode_wr  = cmd_valid && pend_q && (cmd_data[7:2] == 6'd0);
   assign clr_req  = cmd_valid && !pend_q && (cmd_data == CMD_CLR) && op_quiet;
   assign cfg_pend = pend_q;
   assign pin_mode = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         mode_q <= PIN_LEVEL;
      end else if (cmd_valid) begin
         if (pend_q) begin
            pend_q <= 1'b0;
            if (mode_wr) mode_q <= pin_mode_t'(cmd_data[1:0]);
         end else begin
            pend_q <= (cmd_data == CMD_PCFG);
         end
      end
   end
endmodule

// File: rtl/fsu_err_flags.sv
`timescale 1ns/1ps
module fsu_err_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] evt,
   output logic [N-1:0] flags
);
   logic [N-1:0] flags_q;
   assign flags = flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (clr ? '0 : flags_q) | evt;
   end
endmodule

// File: rtl/fsu_rd_snap.sv
`timescale 1ns/1ps
module fsu_rd_snap #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  logic [W-1:0] live,
   output logic [W-1:0] snap
);
   logic         rd_q;
   logic [W-1:0] snap_q;
   assign snap = snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         snap_q <= RST_VAL;
      end else begin
         rd_q <= rd_en;
         if (rd_en && !rd_q) snap_q <= live;
      end
   end
endmodule

// File: rtl/fsu_pin_drv.sv
`timescale 1ns/1ps
module fsu_pin_drv
   import fsu_pkg::*;
#(
   parameter int unsigned PULSE_CLKS = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_t mode,
   input  logic      mode_wr,
   input  logic      busy,
   input  logic      done_erase,
   input  logic      done_write,
   output logic      oe
);
   localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CLKS);

   logic [CNT_W-1:0] cnt_q;
   logic qual;

   assign qual = (done_erase && (mode == PIN_PULSE_ERASE || mode == PIN_PULSE_BOTH)) ||
                 (done_write && (mode == PIN_PULSE_WRITE || mode == PIN_PULSE_BOTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (mode_wr)        cnt_q <= '0;
      else if (qual)           cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign oe = (mode == PIN_LEVEL) ? busy : (cnt_q != '0);
endmodule

// File: rtl/flash_status_unit.sv
`timescale 1ns/1ps
module flash_status_unit
   import fsu_pkg::*;
#(
   parameter int unsigned PULSE_CLKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_data,
   input  logic       eng_busy,
   input  logic       erase_susp,
   input  logic       write_susp,
   input  logic [3:0] err_evt,
   input  logic       done_erase,
   input  logic       done_write,
   input  logic       rd_en,
   output logic [7:0] status_rd,
   output logic       sts_oe,
   output logic       sts_out
);
   if (PULSE_CLKS < 1 || PULSE_CLKS > 65535) begin : g_bad_pulse
      $error("PULSE_CLKS must lie in 1..65535");
   end

   logic            clr_req;
   logic            mode_wr;
   logic            cfg_pend;
   pin_mode_t       pin_mode;
   logic [ERR_N-1:0] err_flags;
   wire  [SR_W-1:0] sr_live;

   fsu_cmd_decode u_dec (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .op_quiet(!eng_busy && !erase_susp && !write_susp),
      .clr_req(clr_req), .mode_wr(mode_wr), .cfg_pend(cfg_pend), .pin_mode(pin_mode)
   );

   fsu_err_flags #(.N(ERR_N)) u_err (
      .clk(clk), .rst_n(rst_n), .clr(clr_req), .evt(err_evt), .flags(err_flags)
   );

   for (genvar i = 0; i < ERR_N; i++) begin : g_errbit
      assign sr_live[ERR_POS[i]] = err_flags[i];
   end
   assign sr_live[POS_RDY]  = !eng_busy;
   assign sr_live[POS_ESUS] = erase_susp;
   assign sr_live[POS_WSUS] = write_susp;
   assign sr_live[0]        = 1'b0;

   fsu_rd_snap #(.W(SR_W), .RST_VAL(SR_RESET)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .live(sr_live), .snap(status_rd)
   );

   fsu_pin_drv #(.PULSE_CLKS(PULSE_CLKS)) u_pin (
      .clk(clk), .rst_n(rst_n), .mode(pin_mode), .mode_wr(mode_wr), .busy(eng_busy),
      .done_erase(done_erase), .done_write(done_write), .oe(sts_oe)
   );

   assign sts_out = 1'b0;
endmodule

// File: rtl/fsu_checker.sv
`timescale 1ns/1ps
module fsu_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_data,
   input logic       eng_busy,
   input logic       erase_susp,
   input logic       write_susp,
   input logic [3:0] err_evt,
   input logic       rd_en,
   input logic [7:0] status_rd,
   input logic       sts_oe,
   input logic       clr_req,
   input logic       cfg_pend,
   input logic [1:0] pin_mode,
   input logic [3:0] err_flags
);
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_req |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

   assert_ignore_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_data == 8'h50 && (eng_busy || erase_susp || write_susp)) |-> !clr_req);

   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (err_flags == $past(err_evt)));

   assert_config_consumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cfg_pend) |-> !clr_req);

   assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && $past(rd_en, 2)) |-> $stable(status_rd));

   assert_ready_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !$past(rd_en)) |=> (status_rd[7] == !$past(eng_busy)));

   assert_level_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode == 2'd0) |-> (sts_oe == eng_busy));
endmodule

bind flash_status_unit fsu_checker i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
   .eng_busy(eng_busy), .erase_susp(erase_susp), .write_susp(write_susp),
   .err_evt(err_evt), .rd_en(rd_en), .status_rd(status_rd), .sts_oe(sts_oe),
   .clr_req(clr_req), .cfg_pend(cfg_pend), .pin_mode(pin_mode), .err_flags(err_flags)
);

// File: tb/test_flash_status_unit.sv
`timescale 1ns/1ps
module test_flash_status_unit;
   localparam int P = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [7:0] cmd_data = 8'h00;
   logic eng_busy = 1'b0, erase_susp = 1'b0, write_susp = 1'b0;
   logic [3:0] err_evt = 4'h0;
   logic done_erase = 1'b0, done_write = 1'b0, rd_en = 1'b0;
   logic [7:0] status_rd;
   logic sts_oe, sts_out;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   flash_status_unit #(.PULSE_CLKS(P)) i_flash_status_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .eng_busy(eng_busy), .erase_susp(erase_susp), .write_susp(write_susp),
      .err_evt(err_evt), .done_erase(done_erase), .done_write(done_write),
      .rd_en(rd_en), .status_rd(status_rd), .sts_oe(sts_oe), .sts_out(sts_out)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d);
      cmd_valid = 1'b1; cmd_data = d; tick(); cmd_valid = 1'b0;
   endtask

   task automatic read_sr(output logic [7:0] v);
      rd_en = 1'b1; tick(); v = status_rd; rd_en = 1'b0; tick();
   endtask

   task automatic pulse_err(input logic [3:0] e);
      err_evt = e; tick(); err_evt = 4'h0;
   endtask

   task automatic expect_pulse(input string req, input bit is_erase, input bit want);
      if (is_erase) done_erase = 1'b1; else done_write = 1'b1;
      tick();
      done_erase = 1'b0; done_write = 1'b0;
      for (int i = 0; i < P; i++) begin
         check(req, {7'd0, sts_oe}, {7'd0, want});
         tick();
      end
      check(req, {7'd0, sts_oe}, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 reset snapshot", status_rd, 8'h80);
      check("R1 pin released", {7'd0, sts_oe}, 8'h00);
      check("R1 pin value", {7'd0, sts_out}, 8'h00);
      read_sr(v); check("R1 idle read", v, 8'h80);
      eng_busy = 1'b1; #1;
      check("R1 level mode after reset", {7'd0, sts_oe}, 8'h01);
      eng_busy = 1'b0;
   endtask

   task automatic t_bits();
      logic [7:0] v;
      eng_busy = 1'b1; tick();
      check("R8 pin driven while busy", {7'd0, sts_oe}, 8'h01);
      read_sr(v); check("R2 busy status", v, 8'h00);
      eng_busy = 1'b0; #1;
      check("R8 pin released when idle", {7'd0, sts_oe}, 8'h00);
      erase_susp = 1'b1; read_sr(v); check("R2 erase suspend bit", v, 8'hC0);
      write_susp = 1'b1; read_sr(v); check("R2 both suspend bits", v, 8'hC4);
      erase_susp = 1'b0; read_sr(v); check("R2 write suspend bit", v, 8'h84);
      write_susp = 1'b0;
   endtask

   task automatic t_sticky();
      logic [7:0] v;
      pulse_err(4'b0001); tick(); read_sr(v); check("R3 event0 sets bit1", v, 8'h82);
      read_sr(v); check("R3 bit1 stays set", v, 8'h82);
      pulse_err(4'b1000); read_sr(v); check("R3 event3 sets bit5", v, 8'hA2);
      pulse_err(4'b0110); read_sr(v); check("R3 events1,2 set bits3,4", v, 8'hBA);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      send(8'h50); read_sr(v); check("R4 clear when idle", v, 8'h80);
   endtask

   task automatic t_clear_ignored();
      logic [7:0] v;
      pulse_err(4'b0010);
      eng_busy = 1'b1; send(8'h50); eng_busy = 1'b0;
      read_sr(v); check("R5 clear ignored while busy", v, 8'h88);
      erase_susp = 1'b1; send(8'h50);
      read_sr(v); check("R5 clear ignored in erase suspend", v, 8'hC8);
      erase_susp = 1'b0; write_susp = 1'b1; send(8'h50);
      read_sr(v); check("R5 clear ignored in write suspend", v, 8'h8C);
      write_susp = 1'b0; send(8'h50);
      read_sr(v); check("R4 clear after suspend ends", v, 8'h80);
   endtask

   task automatic t_race();
      logic [7:0] v;
      pulse_err(4'b0001);
      err_evt = 4'b1000; send(8'h50); err_evt = 4'h0;
      read_sr(v); check("R6 event beats clear", v, 8'hA0);
      send(8'h50); read_sr(v); check("R4 clear after race", v, 8'h80);
   endtask

   task automatic t_snapshot();
      rd_en = 1'b1; tick();
      check("R7 captured on strobe rise", status_rd, 8'h80);
      eng_busy = 1'b1; tick(); tick();
      check("R7 held while strobe high", status_rd, 8'h80);
      rd_en = 1'b0; tick();
      check("R7 held while strobe low", status_rd, 8'h80);
      rd_en = 1'b1; tick();
      check("R7 new value after re-arm", status_rd, 8'h00);
      rd_en = 1'b0; eng_busy = 1'b0; tick();
   endtask

   task automatic t_pin_modes();
      logic [7:0] v;
      send(8'hB8); send(8'h01);
      eng_busy = 1'b1; tick();
      check("R11 busy ignored in pulse mode", {7'd0, sts_oe}, 8'h00);
      eng_busy = 1'b0;
      expect_pulse("R10 write done ignored in erase mode", 1'b0, 1'b0);
      expect_pulse("R10 erase pulse length", 1'b1, 1'b1);
      send(8'hB8); send(8'h02);
      expect_pulse("R10 erase done ignored in write mode", 1'b1, 1'b0);
      expect_pulse("R10 write pulse length", 1'b0, 1'b1);
      send(8'hB8); send(8'h03);
      expect_pulse("R9 both mode erase", 1'b1, 1'b1);
      expect_pulse("R9 both mode write", 1'b0, 1'b1);
      send(8'hB8); send(8'h07);
      expect_pulse("R9 bad code keeps mode", 1'b1, 1'b1);
      pulse_err(4'b0100);
      send(8'hB8); send(8'h50);
      read_sr(v); check("R9 second write not a clear", v, 8'h90);
      expect_pulse("R9 consumed write keeps mode", 1'b0, 1'b1);
      send(8'hB8); send(8'h00);
      eng_busy = 1'b1; #1;
      check("R9 back to level mode", {7'd0, sts_oe}, 8'h01);
      eng_busy = 1'b0; #1;
      check("R8 released after busy", {7'd0, sts_oe}, 8'h00);
      expect_pulse("R9 no pulse in level mode", 1'b1, 1'b0);
   endtask

   initial begin
      #1;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_bits();
      t_sticky();
      t_clear();
      t_clear_ignored();
      t_race();
      t_snapshot();
      t_pin_modes();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule